// File: doc/BRIEF.md
# Bank-Compare Write Guard with Abort

This unit sits on the bus between a CPU with a 24-bit banked address space and its memory. Each valid bus cycle presents its bank byte, which is address bits 23:16. The unit compares that byte with a software-loaded guarded bank value. A compare mask can drop low bank bits from the compare, so one guard can cover a block of neighbouring banks. While the guard is armed and a valid cycle hits the guarded region, the unit forces the read/write line toward memory to "read" for that cycle, so nothing is written. It also pulls the CPU's active-low abort input low for one cycle, so the CPU cancels the current instruction.

When a fault fires, the guard disarms itself. The abort handler can then touch the guarded banks without faulting again, and it re-arms the guard when it is done. A sticky fault flag and a register holding the faulting bank let the handler see what happened. A small register port sets the guarded bank, the mask and the arm bit, and reads all state back.

Top module: `bank_guard`

## Requirements
- R1: After reset, arm = 0, fault flag = 0, abort_n = 1, guarded bank = 0x00, mask = 0xFF and captured bank = 0x00.
- R2: A cycle hits when, for every bank bit i with mask bit i = 1, cpu_bank[i] equals guarded bank bit i. A mask bit of 0 makes that bit always match.
- R3: While arm = 0, mem_rw equals cpu_rw in every cycle, abort_n stays 1, and the flag and captured bank do not change.
- R4: A cycle with cpu_vld = 0 never faults, whatever its bank, and leaves arm set.
- R5: A fault is an armed, valid, hitting cycle. During a fault cycle, mem_rw is 1 (read) in that same cycle, whatever cpu_rw is.
- R6: abort_n is registered. It is 0 in exactly the one cycle that follows a fault cycle, and 1 otherwise.
- R7: A fault clears arm at the clock edge that ends the fault cycle. Arm stays 0 until software writes it to 1, so later hitting cycles pass through.
- R8: A fault sets the sticky flag. Writing the control register with bit 1 = 1 clears the flag. If a fault and such a clear fall in the same cycle, the flag ends up set.
- R9: On each fault, the captured-bank register loads that cycle's cpu_bank.
- R10: Register map on reg_addr: 0 is control (bit 0 arm, bit 1 flag; read as {6'b0, flag, arm}), 1 is the guarded bank, 2 is the mask, and 3 is the captured bank (read-only). Writes take effect at the clock edge. reg_rdata follows reg_addr combinationally.
- R11: If a fault occurs in the same cycle as a write that sets arm, arm ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_bank | input | 8 | Bank byte (address bits 23:16) of the current bus cycle |
| cpu_vld | input | 1 | High when the cycle carries a valid data or program address |
| cpu_rw | input | 1 | CPU read/write: 1 read, 0 write |
| mem_rw | output | 1 | Read/write passed to memory, forced to 1 on a fault |
| abort_n | output | 1 | Registered active-low abort to the CPU |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
All 256 bank values are driven against several guard setups: an exact single-bank match, a mask that drops two low bits (four banks guarded), a mask that keeps only the top bit (half the space), and an all-zero mask (every bank matches). These show whether each mask bit is honoured and whether unmasked bits are really compared. The same sweeps run with the guard disarmed and with the valid strobe low, which tells a correct qualification apart from a compare that ignores arm or valid. Write and read cycles alternate so that both the forced read and the pass-through are seen. Two cases are run with a register write landing in the same cycle as a fault: one that re-arms the guard, and one that clears the flag. These show which side wins.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

    localparam int BANK_W  = 8;
    localparam int REG_AW  = 2;
    localparam int DATA_W  = BANK_W;

    // control register bit positions
    localparam int CTL_ARM_BIT  = 0;
    localparam int CTL_FLAG_BIT = 1;

    typedef enum logic [REG_AW-1:0] {
        RSEL_CTRL = 2'd0,
        RSEL_BANK = 2'd1,
        RSEL_MASK = 2'd2,
        RSEL_CAPT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              arm;
        logic [BANK_W-1:0] bank;
        logic [BANK_W-1:0] mask;
    } guard_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
    } fault_evt_t;

    localparam logic [BANK_W-1:0] MASK_RST = {BANK_W{1'b1}};
    localparam logic [BANK_W-1:0] BANK_RST = '0;

    function automatic logic [DATA_W-1:0] ctrl_word(input logic arm, input logic flag);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_ARM_BIT]  = arm;
        w[CTL_FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/bg_match.sv
module bg_match
    import bank_guard_pkg::*;
(
    input  guard_cfg_t        cfg,
    input  logic              vld,
    input  logic [BANK_W-1:0] bank,
    output fault_evt_t        evt
);
    logic [BANK_W-1:0] bit_ok;

    genvar gi;
    generate
        for (gi = 0; gi < BANK_W; gi++) begin : g_bit
            assign bit_ok[gi] = ~cfg.mask[gi] | (bank[gi] == cfg.bank[gi]);
        end
    endgenerate

    always_comb begin
        evt.hit  = cfg.arm & vld & (&bit_ok);
        evt.bank = bank;
    end
endmodule

// File: rtl/bg_regs.sv
module bg_regs
    import bank_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  fault_evt_t        evt,
    output guard_cfg_t        cfg,
    output logic [DATA_W-1:0] rdata
);
    logic              arm_q;
    logic              flag_q;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] mask_q;
    logic [BANK_W-1:0] capt_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            flag_q <= 1'b0;
            bank_q <= BANK_RST;
            mask_q <= MASK_RST;
            capt_q <= '0;
        end else begin
            if (we) begin
                case (sel)
                    RSEL_CTRL: begin
                        arm_q <= wdata[CTL_ARM_BIT];
                        if (wdata[CTL_FLAG_BIT]) flag_q <= 1'b0;
                    end
                    RSEL_BANK: bank_q <= wdata;
                    RSEL_MASK: mask_q <= wdata;
                    default: ;
                endcase
            end
            // a fault overrides any simultaneous software update
            if (evt.hit) begin
                arm_q  <= 1'b0;
                flag_q <= 1'b1;
                capt_q <= evt.bank;
            end
        end
    end

    always_comb begin
        cfg.arm  = arm_q;
        cfg.bank = bank_q;
        cfg.mask = mask_q;
        case (sel)
            RSEL_CTRL: rdata = ctrl_word(arm_q, flag_q);
            RSEL_BANK: rdata = bank_q;
            RSEL_MASK: rdata = mask_q;
            default:   rdata = capt_q;
        endcase
    end

    // R7
    fault_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> !arm_q);
    // R8
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> flag_q);
    // R9
    fault_captures_chk: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> capt_q == $past(evt.bank));
endmodule

// File: rtl/bg_abort.sv
module bg_abort
    import bank_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_evt_t evt,
    input  logic       cpu_rw,
    output logic       mem_rw,
    output logic       abort_n
);
    logic abort_nq;

    always_ff @(posedge clk) begin
        if (rst) abort_nq <= 1'b1;
        else     abort_nq <= ~evt.hit;
    end

    assign abort_n = abort_nq;
    assign mem_rw  = cpu_rw | evt.hit;

    // R6
    abort_follows_chk: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> !abort_n);
    // R6
    abort_single_chk: assert property (@(posedge clk) disable iff (rst)
        !abort_n |=> abort_n);
    // R5
    write_killed_chk: assert property (@(posedge clk) disable iff (rst)
        evt.hit |-> mem_rw);
endmodule

// File: rtl/bank_guard.sv
module bank_guard
    import bank_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] cpu_bank,
    input  logic              cpu_vld,
    input  logic              cpu_rw,
    output logic              mem_rw,
    output logic              abort_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    guard_cfg_t cfg;
    fault_evt_t evt;

    bg_match u_match (
        .cfg  (cfg),
        .vld  (cpu_vld),
        .bank (cpu_bank),
        .evt  (evt)
    );

    bg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .evt   (evt),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    bg_abort u_abort (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .cpu_rw  (cpu_rw),
        .mem_rw  (mem_rw),
        .abort_n (abort_n)
    );

    // R3
    disarmed_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.arm |-> mem_rw == cpu_rw);
    // R4
    invalid_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_vld |=> abort_n);
endmodule

// File: tb/bank_guard_tb_top.sv
module bank_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cpu_bank;
    logic       cpu_vld;
    logic       cpu_rw;
    logic       mem_rw;
    logic       abort_n;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic       m_arm, m_flag;
    logic [7:0] m_bank, m_mask, m_capt;

    bank_guard dut_i (
        .clk(clk), .rst(rst), .cpu_bank(cpu_bank), .cpu_vld(cpu_vld),
        .cpu_rw(cpu_rw), .mem_rw(mem_rw), .abort_n(abort_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit hits(input logic [7:0] b);
        return (((b ^ m_bank) & m_mask) == 8'h00);
    endfunction

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic check_regs(input string req);
        rd(2'd0, {6'b0, m_flag, m_arm}, req);
        rd(2'd1, m_bank, req);
        rd(2'd2, m_mask, req);
        rd(2'd3, m_capt, req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_vld = 1'b0; cpu_rw = 1'b1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        case (a)
            2'd0: begin m_arm = d[0]; if (d[1]) m_flag = 1'b0; end
            2'd1: m_bank = d;
            2'd2: m_mask = d;
            default: ;
        endcase
    endtask

    // one bus cycle; optional simultaneous register write
    task automatic cyc(input logic [7:0] b, input logic rw, input logic v,
                       input bit do_wr, input logic [7:0] wd, input string req);
        bit f;
        @(negedge clk);
        cpu_bank = b; cpu_rw = rw; cpu_vld = v;
        reg_we = do_wr; reg_addr = 2'd0; reg_wdata = wd;
        f = m_arm & v & hits(b);
        #2;
        chk(mem_rw === (rw | f), req, mem_rw, rw | f);
        @(posedge clk); #2;
        reg_we = 1'b0;
        chk(abort_n === ~f, req, abort_n, ~f);
        if (do_wr) begin m_arm = wd[0]; if (wd[1]) m_flag = 1'b0; end
        if (f) begin m_arm = 1'b0; m_flag = 1'b1; m_capt = b; end
        cpu_vld = 1'b0;
    endtask

    task automatic sweep(input logic [7:0] bk, input logic [7:0] mk, input string req);
        wr(2'd1, bk);
        wr(2'd2, mk);
        for (int b = 0; b < 256; b++) begin
            if (!m_arm) wr(2'd0, 8'h03);
            cyc(b[7:0], b[0], 1'b1, 1'b0, 8'h00, req);
            if (b % 17 == 0) check_regs(req);
        end
        check_regs(req);
    endtask

    initial begin
        rst = 1'b1; cpu_bank = 0; cpu_vld = 0; cpu_rw = 1; reg_we = 0;
        reg_addr = 0; reg_wdata = 0;
        m_arm = 0; m_flag = 0; m_bank = 0; m_mask = 8'hFF; m_capt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        // R1 reset state
        chk(abort_n === 1'b1, "R1", abort_n, 1);
        check_regs("R1");

        // R2 R5 R6 R7 R9 exact, masked-low, top-bit and empty masks
        sweep(8'h5A, 8'hFF, "R2 R5 R6 R7 R9 exact");
        sweep(8'h41, 8'hFC, "R2 R5 R6 R9 block4");
        sweep(8'h80, 8'h80, "R2 R6 R9 half");
        sweep(8'h00, 8'h00, "R2 R7 all");

        // R3 disarmed: hitting writes pass untouched
        wr(2'd0, 8'h02); wr(2'd1, 8'h33); wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
        for (int b = 0; b < 256; b++) cyc(b[7:0], 1'b0, 1'b1, 1'b0, 8'h00, "R3");
        check_regs("R3");

        // R4 invalid cycles while armed
        wr(2'd0, 8'h01);
        for (int b = 0; b < 256; b++) cyc(b[7:0], 1'b0, 1'b0, 1'b0, 8'h00, "R4");
        check_regs("R4");

        // R7 after a fault, further hits pass
        cyc(8'h33, 1'b0, 1'b1, 1'b0, 8'h00, "R7 fault");
        for (int i = 0; i < 4; i++) cyc(8'h33, 1'b0, 1'b1, 1'b0, 8'h00, "R7 disarmed");
        check_regs("R7");

        // R8 flag clear by write, then clear colliding with a fault
        wr(2'd0, 8'h02);
        check_regs("R8 clear");
        wr(2'd0, 8'h01);
        cyc(8'h33, 1'b0, 1'b1, 1'b1, 8'h03, "R8 set wins");
        check_regs("R8 set wins");

        // R11 arming write in the same cycle as a fault
        wr(2'd0, 8'h01);
        cyc(8'h33, 1'b1, 1'b1, 1'b1, 8'h01, "R11");
        check_regs("R11");
        cyc(8'h33, 1'b0, 1'b1, 1'b0, 8'h00, "R11 stays disarmed");

        // R10 register readback of written values
        wr(2'd1, 8'hC3); wr(2'd2, 8'h3C); wr(2'd3, 8'h99);
        check_regs("R10");

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule